// File: doc/BRIEF.md
# E1 CAS Transmit Signaling Inserter

This block puts host-supplied channel-associated signaling into time slot 16 of an outgoing E1 bit stream. The host may write any of sixteen signaling bytes at any moment. Those bytes sit in a host buffer. At the close of every 16-frame multiframe the whole buffer is copied into a line-side shadow shift register. That register then supplies one byte per frame, so host updates never tear a multiframe in progress.

The stream passes through one bit per clock on which the bit strobe is high. The block keeps its own bit and frame position, starting from frame 0, bit 0 at reset. When insertion is enabled, the eight bits of time slot 16 are replaced with the current shadow byte. All other bits, and every bit while insertion is off, pass through unchanged. The frame-0 byte, including its alignment nibble, is sent exactly as the host wrote it. After each transfer the block raises a one-cycle pulse, which tells the host that a new update window has opened. A read port returns either a transmit buffer entry or, with the select clear, the receive-side byte supplied on an input.

Top module: `e1cas_tx_ins`

## Requirements
- R1: After reset the position is frame 0, bit 0, every buffer and shadow entry is 0x00, and `mf_pulse` is low.
- R2: While `ins_en` is 0, `tx_out` equals `tx_in` at every bit position.
- R3: While `ins_en` is 1, `tx_out` equals `tx_in` at every bit position outside 128..135 of the 256-bit frame.
- R4: While `ins_en` is 1, bits 128..135 of frame k (k = 0..15) carry shadow entry k, most significant bit at bit 128. Entry n-1 holds signaling byte SAn: for n = 2..16 the high nibble is channel n-1 ABCD and the low nibble is channel n+14 ABCD.
- R5: A write with `wr_en` high stores `wr_data` into buffer entry `wr_addr`. The whole buffer is copied to the shadow on the strobed bit 255 of frame 15. A write made during a multiframe does not change what that multiframe transmits.
- R6: A write in the same cycle as the transfer is not part of the copy. The multiframe that starts then sends the old value, and the one after it sends the new value.
- R7: Entries that are not written keep their value and are retransmitted in every later multiframe.
- R8: `mf_pulse` is high for exactly one cycle: the cycle after each transfer.
- R9: With `rd_sel` 1, `rd_data` shows buffer entry `rd_addr`, including a write made on the previous edge. With `rd_sel` 0, it shows `rx_rd_data`.
- R10: The bit and frame position advances only on cycles with `bit_ce` high. While `bit_ce` is low, neither the position nor the inserted bit changes.
- R11: Frame 0 sends entry 0 verbatim. No upper nibble is forced, so any alignment or alarm bits come from the host.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_ce | input | 1 | Bit strobe: this cycle carries one line bit |
| tx_in | input | 1 | Incoming transmit data bit |
| ins_en | input | 1 | Signaling insertion enable |
| tx_out | output | 1 | Outgoing data bit, with time slot 16 replaced when enabled |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 4 | Buffer entry written (n-1 selects SAn) |
| wr_data | input | 8 | Signaling byte written |
| rd_sel | input | 1 | 1: read the transmit buffer, 0: pass the receive byte |
| rd_addr | input | 4 | Buffer entry read |
| rx_rd_data | input | 8 | Receive-side signaling byte for the same read |
| rd_data | output | 8 | Read result |
| mf_pulse | output | 1 | One-cycle flag after each multiframe transfer |

## Verification
The hardest case to reach is a host write that lands in the very cycle the buffer is copied. From the ports this is a single clock in every 4096 strobed bits. The bench tracks the line position in its behavioural model and waits until the model reports frame 15, bit 255. It then issues the write on that exact edge and reads time slot 16 in the next two multiframes, expecting the old byte first and the new byte second. A run of random gaps in the bit strobe, together with a long hold in the middle of time slot 16, makes sure that stalled positions neither advance nor move the inserted bit.

// File: rtl/e1cas_pkg.sv
package e1cas_pkg;

  // True when a bit position lies inside a slot window [start, start+width).
  function automatic logic f_in_window(input int unsigned pos,
                                       input int unsigned start,
                                       input int unsigned width);
    return (pos >= start) && (pos < start + width);
  endfunction

  // Index of the byte bit sent at a window position, most significant first.
  function automatic int unsigned f_msb_first(input int unsigned pos,
                                              input int unsigned start,
                                              input int unsigned width);
    return width - 1 - (pos - start);
  endfunction

endpackage

// File: rtl/e1cas_timing.sv
module e1cas_timing #(
  parameter int BITS_PER_FRAME = 256,
  parameter int FRAMES         = 16,
  parameter int SLOT_IDX       = 16,
  parameter int SLOT_BITS      = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         bit_ce,
  output logic                         frame_end,
  output logic                         mf_end,
  output logic                         in_slot,
  output logic [$clog2(SLOT_BITS)-1:0] slot_bit
);
  import e1cas_pkg::*;

  localparam int BIT_W = $clog2(BITS_PER_FRAME);
  localparam int FRM_W = $clog2(FRAMES);
  localparam int SB_W  = $clog2(SLOT_BITS);
  localparam int unsigned SLOT_START = SLOT_IDX * SLOT_BITS;

  logic [BIT_W-1:0] bit_q;
  logic [FRM_W-1:0] frm_q;

  assign frame_end = bit_ce && (bit_q == BIT_W'(BITS_PER_FRAME - 1));
  assign mf_end    = frame_end && (frm_q == FRM_W'(FRAMES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= '0;
      frm_q <= '0;
    end else if (bit_ce) begin
      if (frame_end) begin
        bit_q <= '0;
        frm_q <= mf_end ? '0 : frm_q + 1'b1;
      end else begin
        bit_q <= bit_q + 1'b1;
      end
    end
  end

  assign in_slot  = f_in_window(32'(bit_q), SLOT_START, SLOT_BITS);
  assign slot_bit = in_slot ? SB_W'(f_msb_first(32'(bit_q), SLOT_START, SLOT_BITS))
                            : '0;

endmodule

// File: rtl/e1cas_sigbuf.sv
module e1cas_sigbuf #(
  parameter int ENTRIES = 16,
  parameter int DW      = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [$clog2(ENTRIES)-1:0] wr_addr,
  input  logic [DW-1:0]              wr_data,
  input  logic [$clog2(ENTRIES)-1:0] rd_addr,
  output logic [DW-1:0]              rd_word,
  output logic [ENTRIES*DW-1:0]      image
);
  localparam int AW = $clog2(ENTRIES);

  logic [DW-1:0] ent_q [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ent_q[i] <= '0;
      else if (wr_en && (wr_addr == AW'(i)))
        ent_q[i] <= wr_data;
    end
    assign image[i*DW +: DW] = ent_q[i];
  end

  assign rd_word = ent_q[rd_addr];

endmodule

// File: rtl/e1cas_shadow.sv
module e1cas_shadow #(
  parameter int ENTRIES = 16,
  parameter int DW      = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic                  advance,
  input  logic [ENTRIES*DW-1:0] image_in,
  output logic [DW-1:0]         head_byte
);
  logic [DW-1:0] stage_q [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_stage
    localparam int NXT = (i + 1) % ENTRIES;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        stage_q[i] <= '0;
      else if (load)
        stage_q[i] <= image_in[i*DW +: DW];
      else if (advance)
        stage_q[i] <= stage_q[NXT];
    end
  end

  assign head_byte = stage_q[0];

endmodule

// File: rtl/e1cas_tx_ins.sv
module e1cas_tx_ins #(
  parameter int BITS_PER_FRAME = 256,
  parameter int FRAMES         = 16,
  parameter int SLOT_IDX       = 16,
  parameter int SLOT_BITS      = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bit_ce,
  input  logic                      tx_in,
  input  logic                      ins_en,
  output logic                      tx_out,
  input  logic                      wr_en,
  input  logic [$clog2(FRAMES)-1:0] wr_addr,
  input  logic [SLOT_BITS-1:0]      wr_data,
  input  logic                      rd_sel,
  input  logic [$clog2(FRAMES)-1:0] rd_addr,
  input  logic [SLOT_BITS-1:0]      rx_rd_data,
  output logic [SLOT_BITS-1:0]      rd_data,
  output logic                      mf_pulse
);
  localparam int ENTRIES = FRAMES;
  localparam int DW      = SLOT_BITS;
  localparam int SB_W    = $clog2(SLOT_BITS);

  // Named internal events, observed by the bound checker.
  logic                frame_end;
  logic                mf_end;
  logic                in_slot;
  logic [SB_W-1:0]     slot_bit;
  logic [DW-1:0]       head_byte;
  logic [DW-1:0]       buf_word;
  logic [ENTRIES*DW-1:0] buf_image;
  logic                ins_bit;
  logic                pulse_q;

  e1cas_timing #(
    .BITS_PER_FRAME(BITS_PER_FRAME),
    .FRAMES        (FRAMES),
    .SLOT_IDX      (SLOT_IDX),
    .SLOT_BITS     (SLOT_BITS)
  ) u_timing (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_ce   (bit_ce),
    .frame_end(frame_end),
    .mf_end   (mf_end),
    .in_slot  (in_slot),
    .slot_bit (slot_bit)
  );

  e1cas_sigbuf #(
    .ENTRIES(ENTRIES),
    .DW     (DW)
  ) u_sigbuf (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .rd_addr(rd_addr),
    .rd_word(buf_word),
    .image  (buf_image)
  );

  e1cas_shadow #(
    .ENTRIES(ENTRIES),
    .DW     (DW)
  ) u_shadow (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (mf_end),
    .advance  (frame_end && !mf_end),
    .image_in (buf_image),
    .head_byte(head_byte)
  );

  assign ins_bit = head_byte[slot_bit];
  assign tx_out  = (ins_en && in_slot) ? ins_bit : tx_in;
  assign rd_data = rd_sel ? buf_word : rx_rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= mf_end;
  end
  assign mf_pulse = pulse_q;

endmodule

// File: rtl/e1cas_tx_ins_chk.sv
module e1cas_tx_ins_chk #(
  parameter int SB_W = 3,
  parameter int DW   = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bit_ce,
  input logic            tx_in,
  input logic            tx_out,
  input logic            in_slot,
  input logic [SB_W-1:0] slot_bit,
  input logic [DW-1:0]   head_byte,
  input logic            frame_end,
  input logic            mf_end,
  input logic            mf_pulse
);

  // R8
  pulse_after_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mf_end |=> mf_pulse);

  // R8
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mf_pulse |=> !mf_pulse);

  // R3
  outside_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_slot |-> (tx_out == tx_in));

  // R4
  msb_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_ce && in_slot && (slot_bit != '0)) |=>
      (in_slot && (slot_bit == $past(slot_bit) - 1'b1)));

  // R5
  head_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(head_byte));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_ce |=> ($stable(slot_bit) && $stable(in_slot) && $stable(head_byte)));

endmodule

bind e1cas_tx_ins e1cas_tx_ins_chk #(
  .SB_W($clog2(SLOT_BITS)),
  .DW  (SLOT_BITS)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bit_ce   (bit_ce),
  .tx_in    (tx_in),
  .tx_out   (tx_out),
  .in_slot  (in_slot),
  .slot_bit (slot_bit),
  .head_byte(head_byte),
  .frame_end(frame_end),
  .mf_end   (mf_end),
  .mf_pulse (mf_pulse)
);

// File: tb/test_e1cas_tx_ins.sv
module test_e1cas_tx_ins;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_ce = 1'b0;
  logic       tx_in = 1'b0;
  logic       ins_en = 1'b0;
  logic       tx_out;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       rd_sel = 1'b0;
  logic [3:0] rd_addr = '0;
  logic [7:0] rx_rd_data = '0;
  logic [7:0] rd_data;
  logic       mf_pulse;

  always #4 clk = ~clk;  // 125 MHz

  e1cas_tx_ins i_e1cas_tx_ins (
    .clk(clk), .rst_n(rst_n), .bit_ce(bit_ce), .tx_in(tx_in), .ins_en(ins_en),
    .tx_out(tx_out), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_addr(rd_addr), .rx_rd_data(rx_rd_data),
    .rd_data(rd_data), .mf_pulse(mf_pulse)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model: line position and two byte arrays.
  int         m_b = 0;
  int         m_f = 0;
  logic [7:0] m_buf [16];
  logic [7:0] m_shd [16];
  bit         m_pulse = 0;

  initial for (int i = 0; i < 16; i++) begin m_buf[i] = '0; m_shd[i] = '0; end

  always begin
    @(negedge clk); #3;
    if (!rst_n) begin
      m_b = 0; m_f = 0; m_pulse = 0;
      for (int i = 0; i < 16; i++) begin m_buf[i] = '0; m_shd[i] = '0; end
    end else if (!done) begin
      logic exp_tx;
      bit   win;
      win = (m_b >= 128) && (m_b < 136);
      exp_tx = (ins_en && win) ? m_shd[m_f][7 - (m_b - 128)] : tx_in;
      if (!ins_en)  check("R2 pass-through", tx_out, exp_tx);
      else if (win) check("R4 slot insertion", tx_out, exp_tx);
      else          check("R3 non-slot bit", tx_out, exp_tx);
      check("R9 read port", rd_data, rd_sel ? m_buf[rd_addr] : rx_rd_data);
      check("R8 multiframe pulse", mf_pulse, m_pulse);
      m_pulse = bit_ce && (m_f == 15) && (m_b == 255);
      if (bit_ce) begin
        if (m_f == 15 && m_b == 255)
          for (int i = 0; i < 16; i++) m_shd[i] = m_buf[i];
        if (m_b == 255) begin m_b = 0; m_f = (m_f + 1) % 16; end
        else m_b++;
      end
      if (wr_en) m_buf[wr_addr] = wr_data;
    end
  end

  // Data source
  logic [15:0] lfsr = 16'hACE1;
  always @(negedge clk) begin
    lfsr  <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    tx_in <= lfsr[0];
  end

  // Watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  function automatic logic [7:0] pat(input int i);
    return (i == 0) ? 8'h0B : 8'((i * 37 + 11) ^ 8'h5A);
  endfunction

  task automatic grab(input int fr, output logic [7:0] byt);
    do begin @(negedge clk); #2; end while (!(m_f == fr && m_b == 128));
    for (int k = 0; k < 8; k++) begin
      if (k > 0) begin @(negedge clk); #2; end
      byt[7-k] = tx_out;
    end
  endtask

  task automatic wait_pos(input int fr, input int b);
    do @(negedge clk); while (!(m_f == fr && m_b == b));
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    logic [7:0] b;
    logic       held;
    repeat (5) @(negedge clk);
    ins_en = 1'b1; rd_sel = 1'b1; rd_addr = 4'd5;
    rst_n = 1'b1; bit_ce = 1'b1;
    @(negedge clk); #2;
    check("R1 pulse after reset", mf_pulse, 1'b0);
    check("R1 buffer after reset", rd_data, 8'h00);
    grab(3, b); check("R1 shadow after reset", b, 8'h00);

    for (int i = 0; i < 16; i++) wr(i, pat(i));
    grab(5, b); check("R5 mid-multiframe write not sent", b, 8'h00);
    grab(0, b); check("R11 frame0 byte verbatim", b, pat(0));
    grab(5, b); check("R5 transferred entry", b, pat(5));
    grab(15, b); check("R4 last frame entry", b, pat(15));

    @(negedge clk); rd_addr = 4'd7; #2;
    check("R9 read transmit buffer", rd_data, pat(7));
    @(negedge clk); rd_sel = 1'b0; rx_rd_data = 8'hC3; #2;
    check("R9 read receive byte", rd_data, 8'hC3);
    @(negedge clk); rd_sel = 1'b1;
    wr(9, 8'h66); rd_addr = 4'd9; #2;
    check("R9 read after write", rd_data, 8'h66);

    grab(4, b); check("R7 unwritten entry kept", b, pat(4));
    grab(9, b); check("R7 rewritten entry", b, 8'h66);

    wait_pos(15, 255);
    wr_en = 1'b1; wr_addr = 4'd2; wr_data = 8'hE7;
    @(negedge clk); wr_en = 1'b0; #2;
    check("R8 pulse after transfer", mf_pulse, 1'b1);
    @(negedge clk); #2;
    check("R8 pulse one cycle", mf_pulse, 1'b0);
    grab(2, b); check("R6 boundary write deferred", b, pat(2));
    grab(2, b); check("R6 boundary write next multiframe", b, 8'hE7);

    wr(0, 8'hA5);
    grab(0, b); check("R11 upper nibble from host", b, 8'hA5);

    ins_en = 1'b0;
    do begin @(negedge clk); #2; end while (m_b != 128);
    for (int k = 0; k < 8; k++) begin
      if (k > 0) begin @(negedge clk); #2; end
      check("R2 slot bit passes when disabled", tx_out, tx_in);
    end
    @(negedge clk); ins_en = 1'b1;

    wait_pos(6, 130);
    bit_ce = 1'b0;
    #2; held = tx_out;
    check("R10 held bit value", held, pat(6)[5]);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); #2;
      check("R10 bit held while strobe low", tx_out, held);
    end
    @(negedge clk); bit_ce = 1'b1;

    for (int k = 0; k < 9000; k++) begin
      @(negedge clk);
      bit_ce = ($urandom % 4) != 0;
      if (k % 700 == 5) begin wr_en = 1'b1; wr_addr = 4'(k % 16); wr_data = 8'(k); end
      else wr_en = 1'b0;
      rd_addr = 4'(k % 16);
    end
    @(negedge clk); wr_en = 1'b0; bit_ce = 1'b1;
    repeat (4) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule